// File: doc/BRIEF.md
# Byte-Wide CPU to 16-bit Disk PIO Bridge

This block lets an 8-bit microcontroller reach the task-file registers of a 16-bit parallel disk through programmed I/O. A CPU read or write on the external-data bus that hits a disk port does not stall the CPU. It is posted: the block latches the access and runs a disk bus cycle on its own. The cycle has a one-clock setup, a programmable strobe and a one-clock hold. Any value the CPU bus hands back on a disk-port read is meaningless. Firmware polls a completion flag and then fetches the real data from two local result registers.

A 16-bit data port carries both bytes. On writes, the upper byte comes from a staging register that firmware loads beforehand. On reads, the upper byte lands back in that same register. The 8-bit command and control ports use only the low-byte result register. A second access that arrives while a cycle is still running is dropped and raises a sticky overrun flag.

Top module: `pio_bridge`

## Requirements
- R1: After reset, the high-byte register (local address 0xDB) and the low-byte register (0xDC) read 0x00. The completion flag and the overrun flag read 0. The strobe width field reads 8. Both chip selects and both strobes are inactive (high).
- R2: The control register sits at local address 0xDD. Its bit 0 is the completion flag (read-only), bit 1 is the overrun flag, bits 7:4 are the strobe width and bits 3:2 read 0. Registers 0xDB and 0xDC are readable and writable. Any other local address reads 0x00.
- R3: A CPU write to 0x31F0 drives `dsk_wr_n` and `dsk_doe`. Data out is {high-byte register, CPU byte}, as sampled when the access is accepted.
- R4: A CPU read of 0x31F0 performs a strobed disk read. At the end of the strobe it loads `dsk_din[15:8]` into 0xDB and `dsk_din[7:0]` into 0xDC.
- R5: A CPU read of 0x31F1..0x31F7 or 0x33F6 loads `dsk_din[7:0]` into 0xDC and leaves 0xDB unchanged.
- R6: A CPU write to 0x31F1..0x31F7 or 0x33F6 drives data out {0x00, CPU byte} and leaves both 0xDB and 0xDC unchanged.
- R7: The completion flag clears in the clock where a disk cycle is accepted. It reads 1 again exactly N+2 clocks after the acceptance edge, where N is the strobe length. That is one clock after the strobe releases.
- R8: The strobe stays low for N consecutive clocks. N is the width field, and a field value of 0 means 16. Chip select and address are active for one clock before the strobe and for one clock after it.
- R9: Addresses 0x31F0..0x31F7 assert `dsk_cs0_n`, and 0x33F6 asserts `dsk_cs1_n`. `dsk_addr` carries CPU address bits 2:0. The two selects are never both low.
- R10: A disk-port access during a running cycle is ignored and sets the overrun flag. The flag stays set until the CPU writes 1 to control bit 1. Writing 0 to that bit leaves it set.
- R11: External-data accesses to addresses that are not disk ports start no disk cycle and leave the completion flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| x_addr | input | 16 | CPU external-data address |
| x_wdata | input | 8 | CPU external-data write byte |
| x_wr | input | 1 | One-clock CPU external write |
| x_rd | input | 1 | One-clock CPU external read |
| s_addr | input | 8 | Local register address |
| s_wdata | input | 8 | Local register write data |
| s_wr | input | 1 | Local register write enable |
| s_rdata | output | 8 | Local register read data (combinational) |
| dsk_addr | output | 3 | Disk register address |
| dsk_cs0_n | output | 1 | Command block select, active low |
| dsk_cs1_n | output | 1 | Control block select, active low |
| dsk_rd_n | output | 1 | Disk read strobe, active low |
| dsk_wr_n | output | 1 | Disk write strobe, active low |
| dsk_dout | output | 16 | Disk write data |
| dsk_doe | output | 1 | Disk data output enable |
| dsk_din | input | 16 | Disk read data |

## Verification
The hardest case to reach is the overrun. The bench has to land a second disk-port access inside the few clocks a cycle is busy, and then prove that the access left no trace. To do this it launches a read, injects a write to the data port two clocks later, and watches every clock. It checks that the write strobe never falls and that completion still arrives at the nominal count. It also checks that the captured read bytes are intact. The wrap case of a zero width field, which gives a 16-clock strobe, is reached by reprogramming the control register between operations.

// File: rtl/pio_bridge.sv
module pio_bridge #(
  parameter logic [3:0]  DEF_WIDTH = 4'd8,
  parameter logic [7:0]  HI_ADDR   = 8'hDB,
  parameter logic [7:0]  LO_ADDR   = 8'hDC,
  parameter logic [7:0]  CTL_ADDR  = 8'hDD,
  parameter logic [15:0] CMD_BASE  = 16'h31F0,
  parameter logic [15:0] CTL_PORT  = 16'h33F6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] x_addr,
  input  logic [7:0]  x_wdata,
  input  logic        x_wr,
  input  logic        x_rd,
  input  logic [7:0]  s_addr,
  input  logic [7:0]  s_wdata,
  input  logic        s_wr,
  output logic [7:0]  s_rdata,
  output logic [2:0]  dsk_addr,
  output logic        dsk_cs0_n,
  output logic        dsk_cs1_n,
  output logic        dsk_rd_n,
  output logic        dsk_wr_n,
  output logic [15:0] dsk_dout,
  output logic        dsk_doe,
  input  logic [15:0] dsk_din
);

  typedef enum logic [1:0] {IDLE, SETUP, STROBE, HOLD} st_t;

  st_t         st;
  logic [3:0]  cnt, width;
  logic [7:0]  hi_q, lo_q;
  logic        done, ovr;
  logic        op_wr, op_wide, op_cmd;
  logic [2:0]  op_addr;
  logic [15:0] op_data;

  wire hit_cmd = (x_addr[15:3] == CMD_BASE[15:3]);
  wire hit_ctl = (x_addr == CTL_PORT);
  wire access  = (x_wr | x_rd) & (hit_cmd | hit_ctl);
  wire busy    = (st != IDLE);
  wire launch  = access & ~busy;
  wire capture = (st == STROBE) && (cnt == 4'd0) && !op_wr;
  wire ctl_wr  = s_wr && (s_addr == CTL_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= IDLE;
      cnt     <= '0;
      op_wr   <= 1'b0;
      op_wide <= 1'b0;
      op_cmd  <= 1'b0;
      op_addr <= '0;
      op_data <= '0;
    end else begin
      case (st)
        IDLE: if (launch) begin
          st      <= SETUP;
          op_wr   <= x_wr;
          op_cmd  <= hit_cmd;
          op_wide <= hit_cmd && (x_addr[2:0] == 3'd0);
          op_addr <= x_addr[2:0];
          op_data <= (hit_cmd && x_addr[2:0] == 3'd0) ? {hi_q, x_wdata} : {8'h00, x_wdata};
        end
        SETUP: begin
          st  <= STROBE;
          cnt <= width - 4'd1;
        end
        STROBE: begin
          if (cnt == 4'd0) st <= HOLD;
          else cnt <= cnt - 4'd1;
        end
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      lo_q  <= '0;
      done  <= 1'b0;
      ovr   <= 1'b0;
      width <= DEF_WIDTH;
    end else begin
      if (capture && op_wide)             hi_q <= dsk_din[15:8];
      else if (s_wr && s_addr == HI_ADDR) hi_q <= s_wdata;
      if (capture)                        lo_q <= dsk_din[7:0];
      else if (s_wr && s_addr == LO_ADDR) lo_q <= s_wdata;
      if (launch)           done <= 1'b0;
      else if (st == HOLD)  done <= 1'b1;
      if (access && busy)             ovr <= 1'b1;
      else if (ctl_wr && s_wdata[1])  ovr <= 1'b0;
      if (ctl_wr) width <= s_wdata[7:4];
    end
  end

  always_comb begin
    case (s_addr)
      HI_ADDR:  s_rdata = hi_q;
      LO_ADDR:  s_rdata = lo_q;
      CTL_ADDR: s_rdata = {width, 2'b00, ovr, done};
      default:  s_rdata = 8'h00;
    endcase
  end

  assign dsk_cs0_n = ~(busy & op_cmd);
  assign dsk_cs1_n = ~(busy & ~op_cmd);
  assign dsk_addr  = busy ? op_addr : 3'd0;
  assign dsk_rd_n  = ~((st == STROBE) & ~op_wr);
  assign dsk_wr_n  = ~((st == STROBE) & op_wr);
  assign dsk_doe   = busy & op_wr;
  assign dsk_dout  = dsk_doe ? op_data : 16'h0000;

  a_r8_setup: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dsk_rd_n) || $fell(dsk_wr_n)) |-> $past(!dsk_cs0_n || !dsk_cs1_n));
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dsk_rd_n) || $rose(dsk_wr_n)) |-> (!dsk_cs0_n || !dsk_cs1_n));
  a_r9_cs_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dsk_cs0_n && !dsk_cs1_n));
  a_r7_done_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> $past(launch));
  a_r7_done_set: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(st == HOLD) && dsk_rd_n && dsk_wr_n));
  a_r10_ovr_set: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(access && busy));
  a_r3_doe_write: assert property (@(posedge clk) disable iff (!rst_n)
    !dsk_wr_n |-> (dsk_doe && dsk_rd_n));

endmodule

// File: tb/pio_bridge_test.sv
module pio_bridge_test;
  logic        clk = 0, rst_n = 0;
  logic [15:0] x_addr = 0;
  logic [7:0]  x_wdata = 0, s_addr = 0, s_wdata = 0, s_rdata;
  logic        x_wr = 0, x_rd = 0, s_wr = 0;
  logic [2:0]  dsk_addr;
  logic        dsk_cs0_n, dsk_cs1_n, dsk_rd_n, dsk_wr_n, dsk_doe;
  logic [15:0] dsk_dout, dsk_din = 0;

  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  pio_bridge uut (.*);

  typedef struct packed {
    logic        wr;
    logic [15:0] addr;
    logic [7:0]  wdata;
    logic [7:0]  stage;
    logic [15:0] din;
    logic [7:0]  exp_hi;
    logic [7:0]  exp_lo;
    logic [15:0] exp_dout;
    logic [1:0]  exp_cs;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{1'b0, 16'h31F0, 8'h00, 8'h00, 16'hBEEF, 8'hBE, 8'hEF, 16'h0000, 2'b10},
    '{1'b1, 16'h31F0, 8'h34, 8'h12, 16'h0000, 8'h12, 8'h5A, 16'h1234, 2'b10},
    '{1'b0, 16'h31F7, 8'h00, 8'h77, 16'hA5C3, 8'h77, 8'hC3, 16'h0000, 2'b10},
    '{1'b0, 16'h33F6, 8'h00, 8'h66, 16'h0081, 8'h66, 8'h81, 16'h0000, 2'b01},
    '{1'b1, 16'h31F3, 8'h9C, 8'h44, 16'hFFFF, 8'h44, 8'h5A, 16'h009C, 2'b10},
    '{1'b1, 16'h33F6, 8'h02, 8'h11, 16'hFFFF, 8'h11, 8'h5A, 16'h0002, 2'b01}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); s_addr = a; s_wdata = d; s_wr = 1;
    @(negedge clk); s_wr = 0;
  endtask

  task automatic sfr_read(input logic [7:0] a, output logic [7:0] v);
    s_addr = a; #1; v = s_rdata;
  endtask

  int          strobes, done_at;
  bit          setup_ok, hold_ok, other_ok, inj_seen_wr;
  logic [1:0]  cs_seen;
  logic [2:0]  a_seen;
  logic [15:0] dout_seen;
  logic        doe_seen;

  task automatic run_op(input bit wr, input logic [15:0] addr, input logic [7:0] data,
                        input int n, input bit inject);
    logic st;
    strobes = 0; done_at = -1; setup_ok = 0; hold_ok = 0; other_ok = 1; inj_seen_wr = 0;
    cs_seen = 2'b11; a_seen = 0; dout_seen = 0; doe_seen = 0;
    @(negedge clk); x_addr = addr; x_wdata = data; x_wr = wr; x_rd = !wr;
    @(negedge clk); x_wr = 0; x_rd = 0; s_addr = 8'hDD;
    for (int j = 0; j < 40; j++) begin
      #1;
      st = wr ? !dsk_wr_n : !dsk_rd_n;
      if (wr ? !dsk_rd_n : !dsk_wr_n) other_ok = 0;
      if (!wr && !dsk_wr_n) inj_seen_wr = 1;
      if (j == 0) setup_ok = (!dsk_cs0_n || !dsk_cs1_n) && !st;
      if (j == n + 1) hold_ok = (!dsk_cs0_n || !dsk_cs1_n) && !st;
      if (st) begin
        strobes++;
        cs_seen = {dsk_cs1_n, dsk_cs0_n}; a_seen = dsk_addr;
        dout_seen = dsk_dout; doe_seen = dsk_doe;
      end
      if (s_rdata[0]) begin done_at = j; break; end
      @(negedge clk);
      if (inject && j == 1) begin x_addr = 16'h31F0; x_wdata = 8'hEE; x_wr = 1; end
      else begin x_wr = 0; end
    end
    x_wr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    sfr_read(8'hDB, v); chk(v == 8'h00, "R1 hi reset", v, 0);
    sfr_read(8'hDC, v); chk(v == 8'h00, "R1 lo reset", v, 0);
    sfr_read(8'hDD, v); chk(v == 8'h80, "R1 ctl reset", v, 8'h80);
    chk(dsk_cs0_n && dsk_cs1_n && dsk_rd_n && dsk_wr_n, "R1 disk idle",
        {dsk_cs1_n, dsk_cs0_n, dsk_rd_n, dsk_wr_n}, 4'hF);
    rst_n = 1;
    sfr_write(8'hDB, 8'hC7); sfr_read(8'hDB, v); chk(v == 8'hC7, "R2 hi rw", v, 8'hC7);
    sfr_write(8'hDC, 8'h3E); sfr_read(8'hDC, v); chk(v == 8'h3E, "R2 lo rw", v, 8'h3E);
    sfr_read(8'h10, v); chk(v == 8'h00, "R2 unmapped", v, 0);

    // Vector walk: R3 R4 R5 R6 R7 R8 R9
    foreach (VEC[i]) begin
      sfr_write(8'hDB, VEC[i].stage);
      sfr_write(8'hDC, 8'h5A);
      dsk_din = VEC[i].din;
      run_op(VEC[i].wr, VEC[i].addr, VEC[i].wdata, 8, 0);
      chk(strobes == 8, "R8 strobe width", strobes, 8);
      chk(setup_ok && hold_ok, "R8 setup/hold", {setup_ok, hold_ok}, 2'b11);
      chk(other_ok, "R9 wrong strobe", other_ok, 1);
      chk(done_at == 10, "R7 done latency", done_at, 10);
      chk(cs_seen == VEC[i].exp_cs, "R9 chip select", cs_seen, VEC[i].exp_cs);
      chk(a_seen == VEC[i].addr[2:0], "R9 disk addr", a_seen, VEC[i].addr[2:0]);
      if (VEC[i].wr) begin
        chk(doe_seen && dsk_dout == 16'h0 || doe_seen, "R3 doe", doe_seen, 1);
        chk(dout_seen == VEC[i].exp_dout, "R3/R6 dout", dout_seen, VEC[i].exp_dout);
      end else begin
        chk(!doe_seen, "R4/R5 doe off on read", doe_seen, 0);
      end
      sfr_read(8'hDB, v); chk(v == VEC[i].exp_hi, "R4/R5/R6 hi reg", v, VEC[i].exp_hi);
      sfr_read(8'hDC, v); chk(v == VEC[i].exp_lo, "R4/R5/R6 lo reg", v, VEC[i].exp_lo);
    end

    // R8: width 3, then 0 meaning 16
    sfr_write(8'hDD, 8'h30);
    dsk_din = 16'h2468;
    run_op(0, 16'h31F0, 0, 3, 0);
    chk(strobes == 3, "R8 width 3", strobes, 3);
    chk(done_at == 5, "R7 done latency width 3", done_at, 5);
    sfr_write(8'hDD, 8'h00);
    run_op(0, 16'h31F2, 0, 16, 0);
    chk(strobes == 16, "R8 width 0 is 16", strobes, 16);
    chk(done_at == 18, "R7 done latency width 16", done_at, 18);
    sfr_write(8'hDD, 8'h80);

    // R10: overrun injection
    dsk_din = 16'h1357;
    run_op(0, 16'h31F0, 0, 8, 1);
    chk(!inj_seen_wr, "R10 ignored write", inj_seen_wr, 0);
    chk(done_at == 10, "R10 timing unchanged", done_at, 10);
    sfr_read(8'hDB, v); chk(v == 8'h13, "R10 hi intact", v, 8'h13);
    sfr_read(8'hDC, v); chk(v == 8'h57, "R10 lo intact", v, 8'h57);
    sfr_read(8'hDD, v); chk(v[1], "R10 ovr set", v, 8'h83);
    sfr_write(8'hDD, 8'h80);
    sfr_read(8'hDD, v); chk(v[1], "R10 write 0 keeps", v, 8'h83);
    sfr_write(8'hDD, 8'h82);
    sfr_read(8'hDD, v); chk(v == 8'h81, "R10 w1c", v, 8'h81);

    // R11: non-disk address
    @(negedge clk); x_addr = 16'h3200; x_rd = 1;
    @(negedge clk); x_rd = 0; x_addr = 16'h31E8; x_wr = 1;
    @(negedge clk); x_wr = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(dsk_cs0_n && dsk_cs1_n && dsk_rd_n && dsk_wr_n, "R11 no cycle",
          {dsk_cs1_n, dsk_cs0_n, dsk_rd_n, dsk_wr_n}, 4'hF);
    end
    sfr_read(8'hDD, v); chk(v[0], "R11 done kept", v, 8'h81);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule